// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block executes the sixteen data-processing operations of a 32-bit load/store core's integer pipeline. Each cycle it may accept one instruction word with `inValid`. Along with it come the first operand, the second operand (already passed through the external barrel shifter), the shifter's carry-out and the current N, Z, C, V flags. From the instruction word the block decides whether it belongs to the register-shift data-processing class. It extracts the operation, the flag-save bit, the destination index and the condition field, and tests the condition against the incoming flags. It then computes the logical or arithmetic result and the next flag values.

The block returns four things one cycle after acceptance: the result, a destination-write enable, the destination index and the next flags. Compare and test operations update flags but never write a register. A failed condition, or an instruction outside the class, leaves the destination untouched and passes the incoming flags straight through. The flag bus is ordered N in bit 3, Z in bit 2, C in bit 1 and V in bit 0.

Top module: `dp_alu`

## Requirements
- R1: An instruction is in class (`classHit`=1) only when bits 27:25 and bit 4 are all zero. Opcodes 8 to 11 with bit 20 clear are also excluded. An excluded instruction gives `wrEn`=0 and `flagsOut`=`flagsIn`.
- R2: The opcode is taken from bits 24:21, the flag-save bit from bit 20, the condition from bits 31:28, and `rdIdx` from bits 15:12.
- R3: The condition codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 always, 15 never. A failed condition gives `wrEn`=0 and `flagsOut`=`flagsIn`.
- R4: Logical opcodes compute the following from A (`opA`) and B (`opB`): 0 and 8 give A&B; 1 and 9 give A^B; 12 gives A|B; 13 gives B; 14 gives A&~B; 15 gives ~B.
- R5: Arithmetic opcodes compute: 2 and 10 give A-B; 3 gives B-A; 4 and 11 give A+B; 5 gives A+B+C; 6 gives A-B-!C; 7 gives B-A-!C. All are modulo 2^32.
- R6: Opcodes 8 to 11 never assert `wrEn`. An in-class instruction with any other opcode and a passing condition asserts `wrEn`.
- R7: For logical opcodes with flags saved, N is result bit 31, Z is result==0, C is `shCarry` and V is kept.
- R8: For addition opcodes (4, 5, 11) with flags saved, C is the carry out of bit 31. V is set when both addends share a sign that the result does not.
- R9: For subtraction opcodes (2, 3, 6, 7, 10) with flags saved, C is 1 when no borrow occurs. V is set when the minuend and subtrahend signs differ and the result sign differs from the minuend.
- R10: With bit 20 clear, `flagsOut` equals `flagsIn`.
- R11: All outputs are registered. They are due one cycle after `inValid`. `outValid` marks them, and `wrEn` is 0 whenever `outValid` is 0.
- R12: `result` carries the operation value for every in-class instruction, whether or not its condition passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction and operands present this cycle |
| instr | input | 32 | Instruction word |
| opA | input | DATA_W | First operand |
| opB | input | DATA_W | Shifted second operand |
| shCarry | input | 1 | Shifter carry-out |
| flagsIn | input | 4 | Current flags {N,Z,C,V} |
| outValid | output | 1 | Registered results valid |
| classHit | output | 1 | Instruction belongs to the data-processing class |
| wrEn | output | 1 | Destination write enable |
| rdIdx | output | 4 | Destination register index |
| result | output | DATA_W | Operation result |
| flagsOut | output | 4 | Next flags {N,Z,C,V} |

## Verification
Every output comes from a single register stage, so each result of an accepted instruction is due exactly one clock after the edge that captured it. The bench drives stimulus on the falling edge and samples on the next falling edge, which lies half a period after the capturing rising edge. The operand sweep covers every opcode with and without flag save, against carry and overflow corner operands and several incoming flag patterns. A second sweep crosses all condition codes with all sixteen flag states, and excluded encodings and idle cycles are sampled in the same one-cycle slot.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flagsT;

  typedef enum logic [1:0] {
    GRP_LOGIC = 2'd0,
    GRP_ADD   = 2'd1,
    GRP_SUB   = 2'd2
  } grpT;

  typedef enum logic [2:0] {
    LF_AND = 3'd0,
    LF_EOR = 3'd1,
    LF_ORR = 3'd2,
    LF_MOV = 3'd3,
    LF_BIC = 3'd4,
    LF_MVN = 3'd5
  } logicFnT;

  // Strobes from control to datapath
  typedef struct packed {
    logic    hit;
    logic    condPass;
    logic    writeRd;
    logic    setFlags;
    grpT     grp;
    logicFnT lfn;
    logic    swap;
    logic    useFlagC;
  } strobeT;

endpackage

// File: rtl/dp_alu_ctrl.sv
module dp_alu_ctrl
  import dp_alu_pkg::*;
(
  input  logic [3:0] condField,
  input  logic [3:0] classBits,
  input  logic [3:0] opField,
  input  logic       sBit,
  input  flagsT      flagsIn,
  output strobeT     strobe
);

  logic condOk;
  logic cmpGroup;

  assign cmpGroup = (opField[3:2] == 2'b10);

  // R3 condition evaluation
  always_comb begin
    unique case (condField)
      4'd0:    condOk = flagsIn.z;
      4'd1:    condOk = !flagsIn.z;
      4'd2:    condOk = flagsIn.c;
      4'd3:    condOk = !flagsIn.c;
      4'd4:    condOk = flagsIn.n;
      4'd5:    condOk = !flagsIn.n;
      4'd6:    condOk = flagsIn.v;
      4'd7:    condOk = !flagsIn.v;
      4'd8:    condOk = flagsIn.c && !flagsIn.z;
      4'd9:    condOk = !flagsIn.c || flagsIn.z;
      4'd10:   condOk = (flagsIn.n == flagsIn.v);
      4'd11:   condOk = (flagsIn.n != flagsIn.v);
      4'd12:   condOk = !flagsIn.z && (flagsIn.n == flagsIn.v);
      4'd13:   condOk = flagsIn.z || (flagsIn.n != flagsIn.v);
      4'd14:   condOk = 1'b1;
      default: condOk = 1'b0;
    endcase
  end

  // R1 R2 R6 opcode decode
  always_comb begin
    strobe          = '0;
    strobe.hit      = (classBits == 4'd0) && !(cmpGroup && !sBit);
    strobe.condPass = condOk;
    strobe.writeRd  = !cmpGroup;
    strobe.setFlags = sBit;
    strobe.grp      = GRP_LOGIC;
    strobe.lfn      = LF_AND;
    strobe.swap     = 1'b0;
    strobe.useFlagC = 1'b0;
    unique case (opField)
      4'd0, 4'd8:  strobe.lfn = LF_AND;
      4'd1, 4'd9:  strobe.lfn = LF_EOR;
      4'd2, 4'd10: strobe.grp = GRP_SUB;
      4'd3: begin
        strobe.grp  = GRP_SUB;
        strobe.swap = 1'b1;
      end
      4'd4, 4'd11: strobe.grp = GRP_ADD;
      4'd5: begin
        strobe.grp      = GRP_ADD;
        strobe.useFlagC = 1'b1;
      end
      4'd6: begin
        strobe.grp      = GRP_SUB;
        strobe.useFlagC = 1'b1;
      end
      4'd7: begin
        strobe.grp      = GRP_SUB;
        strobe.swap     = 1'b1;
        strobe.useFlagC = 1'b1;
      end
      4'd12:   strobe.lfn = LF_ORR;
      4'd13:   strobe.lfn = LF_MOV;
      4'd14:   strobe.lfn = LF_BIC;
      default: strobe.lfn = LF_MVN;
    endcase
  end

endmodule

// File: rtl/dp_alu_datapath.sv
module dp_alu_datapath
  import dp_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  strobeT            strobe,
  input  logic [3:0]        rdField,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              shCarry,
  input  flagsT             flagsIn,
  output logic              outValid,
  output logic              classHit,
  output logic              wrEn,
  output logic [3:0]        rdIdx,
  output logic [DATA_W-1:0] result,
  output flagsT             flagsOut
);

  localparam int SUM_W = DATA_W + 1;
  localparam int MSB   = DATA_W - 1;

  logic [DATA_W-1:0] opX;
  logic [DATA_W-1:0] opY;
  logic [DATA_W-1:0] ySum;
  logic              carryIn;
  logic [SUM_W-1:0]  sumFull;
  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] aluRes;
  flagsT             newFlags;
  flagsT             nextFlags;
  logic              commit;

  // R5 operand routing and adder
  assign opX     = strobe.swap ? opB : opA;
  assign opY     = strobe.swap ? opA : opB;
  assign ySum    = (strobe.grp == GRP_SUB) ? ~opY : opY;
  assign carryIn = strobe.useFlagC ? flagsIn.c : (strobe.grp == GRP_SUB);
  assign sumFull = {1'b0, opX} + {1'b0, ySum} + {{DATA_W{1'b0}}, carryIn};

  // R4 logic unit
  always_comb begin
    unique case (strobe.lfn)
      LF_AND:  logicRes = opA & opB;
      LF_EOR:  logicRes = opA ^ opB;
      LF_ORR:  logicRes = opA | opB;
      LF_MOV:  logicRes = opB;
      LF_BIC:  logicRes = opA & ~opB;
      LF_MVN:  logicRes = ~opB;
      default: logicRes = '0;
    endcase
  end

  assign aluRes = (strobe.grp == GRP_LOGIC) ? logicRes : sumFull[DATA_W-1:0];

  // R7 R8 R9 flag generation
  always_comb begin
    newFlags.n = aluRes[MSB];
    newFlags.z = (aluRes == '0);
    if (strobe.grp == GRP_LOGIC) begin
      newFlags.c = shCarry;
      newFlags.v = flagsIn.v;
    end else begin
      newFlags.c = sumFull[DATA_W];
      newFlags.v = (opX[MSB] == ySum[MSB]) && (aluRes[MSB] != opX[MSB]);
    end
  end

  // R3 R10 commit gating
  assign commit    = strobe.hit && strobe.condPass;
  assign nextFlags = (commit && strobe.setFlags) ? newFlags : flagsIn;

  // R11 output register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      classHit <= 1'b0;
      wrEn     <= 1'b0;
      rdIdx    <= '0;
      result   <= '0;
      flagsOut <= '0;
    end else begin
      outValid <= inValid;
      wrEn     <= inValid && commit && strobe.writeRd;
      if (inValid) begin
        classHit <= strobe.hit;
        rdIdx    <= rdField;
        result   <= aluRes;
        flagsOut <= nextFlags;
      end
    end
  end

  // R11
  wr_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> outValid);

  // R1
  wr_needs_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> classHit);

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              shCarry,
  input  logic [3:0]        flagsIn,
  output logic              outValid,
  output logic              classHit,
  output logic              wrEn,
  output logic [3:0]        rdIdx,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flagsOut
);

  strobeT strobe;
  flagsT  flagsOutS;
  logic   unusedInstr;

  assign unusedInstr = ^{instr[19:16], instr[11:5], instr[3:0]};

  dp_alu_ctrl u_ctrl (
    .condField (instr[31:28]),
    .classBits ({instr[27:25], instr[4]}),
    .opField   (instr[24:21]),
    .sBit      (instr[20]),
    .flagsIn   (flagsT'(flagsIn)),
    .strobe    (strobe)
  );

  dp_alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .rdField  (instr[15:12]),
    .opA      (opA),
    .opB      (opB),
    .shCarry  (shCarry),
    .flagsIn  (flagsT'(flagsIn)),
    .outValid (outValid),
    .classHit (classHit),
    .wrEn     (wrEn),
    .rdIdx    (rdIdx),
    .result   (result),
    .flagsOut (flagsOutS)
  );

  assign flagsOut = flagsOutS;

  // R1
  class_miss_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(instr[27:25] != 3'b000)
      |-> !classHit && !wrEn && (flagsOut == $past(flagsIn)));

  // R6
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(instr[24:23] == 2'b10) |-> !wrEn);

  // R10
  s_clear_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !$past(instr[20]) |-> flagsOut == $past(flagsIn));

  // R3
  never_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(instr[31:28] == 4'hF)
      |-> !wrEn && (flagsOut == $past(flagsIn)));

  // R2
  rd_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> rdIdx == $past(instr[15:12]));

  // R7
  logic_v_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(instr[24:21] == 4'd13) |-> flagsOut[0] == $past(flagsIn[0]));

endmodule

// File: tb/tb_dp_alu.sv
module tb_dp_alu;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic [31:0]  instr;
  logic [W-1:0] opA, opB;
  logic         shCarry;
  logic [3:0]   flagsIn;
  logic         outValid, classHit, wrEn;
  logic [3:0]   rdIdx, flagsOut;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_alu #(.DATA_W(W)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr),
    .opA(opA), .opB(opB), .shCarry(shCarry), .flagsIn(flagsIn),
    .outValid(outValid), .classHit(classHit), .wrEn(wrEn),
    .rdIdx(rdIdx), .result(result), .flagsOut(flagsOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h instr=%h a=%h b=%h f=%h",
               req, act, exp, instr, opA, opB, flagsIn);
    end
  endtask

  function automatic logic condTrue(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      0: return z;          1: return !z;
      2: return c;          3: return !c;
      4: return n;          5: return !n;
      6: return v;          7: return !v;
      8: return c & ~z;     9: return ~c | z;
      10: return ~(n ^ v);  11: return n ^ v;
      12: return ~z & ~(n ^ v);
      13: return z | (n ^ v);
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Reference from the requirements
  task automatic model(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                       input logic sc, input logic [3:0] fi,
                       output logic hit, output logic wr, output logic [31:0] r,
                       output logic [3:0] fo);
    logic [3:0] op;
    logic s, cin, nf, zf, cf, vf;
    logic [32:0] wide;
    logic [31:0] m, sub;
    op  = ins[24:21];
    s   = ins[20];
    cin = fi[1];
    hit = (ins[27:25] == 0) && !ins[4] && !(op >= 8 && op <= 11 && !s);
    cf = sc; vf = fi[0];
    m = a; sub = b;
    case (op)
      0, 8: r = a & b;
      1, 9: r = a ^ b;
      12: r = a | b;
      13: r = b;
      14: r = a & ~b;
      15: r = ~b;
      4, 5, 11: begin
        wide = {1'b0, a} + {1'b0, b} + ((op == 5) ? {32'd0, cin} : 33'd0);
        r  = wide[31:0];
        cf = wide[32];
        vf = (a[31] == b[31]) && (r[31] != a[31]);
      end
      default: begin
        if (op == 3 || op == 7) begin m = b; sub = a; end
        if (op == 6 || op == 7) begin
          r  = m - sub - {31'd0, !cin};
          cf = ({1'b0, m} >= ({1'b0, sub} + {32'd0, !cin}));
        end else begin
          r  = m - sub;
          cf = (m >= sub);
        end
        vf = (m[31] != sub[31]) && (r[31] != m[31]);
      end
    endcase
    nf = r[31];
    zf = (r == 0);
    wr = hit && condTrue(ins[31:28], fi) && !(op >= 8 && op <= 11);
    if (hit && condTrue(ins[31:28], fi) && s) fo = {nf, zf, cf, vf};
    else fo = fi;
  endtask

  task automatic runVec(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                        input logic sc, input logic [3:0] fi, input string tag);
    logic eHit, eWr;
    logic [31:0] eRes;
    logic [3:0] eFl;
    model(ins, a, b, sc, fi, eHit, eWr, eRes, eFl);
    instr = ins; opA = a; opB = b; shCarry = sc; flagsIn = fi; inValid = 1'b1;
    @(negedge clk);
    check({tag, " R11 outValid"}, {31'd0, outValid}, 32'd1);
    check({tag, " R1 classHit"}, {31'd0, classHit}, {31'd0, eHit});
    check({tag, " R6 wrEn"}, {31'd0, wrEn}, {31'd0, eWr});
    check({tag, " R2 rdIdx"}, {28'd0, rdIdx}, {28'd0, ins[15:12]});
    check({tag, " R10 flags"}, {28'd0, flagsOut}, {28'd0, eFl});
    if (eHit) check({tag, " R12 result"}, result, eRes);
  endtask

  initial begin
    logic [31:0] aSet [8];
    logic [31:0] bSet [8];
    logic [3:0]  fSet [4];
    aSet = '{32'h0, 32'h1, 32'h7fffffff, 32'h80000000, 32'hffffffff, 32'h5, 32'h80000000, 32'h12345678};
    bSet = '{32'h0, 32'h1, 32'h1, 32'h80000000, 32'h1, 32'h7, 32'h1, 32'hf0f0f0f0};
    fSet = '{4'h0, 4'h1, 4'h2, 4'hf};
    rstN = 1'b0; inValid = 1'b0; instr = '0; opA = '0; opB = '0; shCarry = 1'b0; flagsIn = '0;
    repeat (3) @(negedge clk);
    check("R11 reset outValid", {31'd0, outValid}, 32'd0);
    check("R11 reset wrEn", {31'd0, wrEn}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R4 R5 R7 R8 R9 R10 opcode sweep
    for (int op = 0; op < 16; op++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 8; p++)
          for (int f = 0; f < 4; f++)
            runVec({4'hE, 3'b000, op[3:0], s[0], 4'h3, op[3:0], 7'd0, 1'b0, 4'h2},
                   aSet[p], bSet[p], p[0], fSet[f], "sweep R4 R5 R7 R8 R9");

    // R3 condition sweep with MOV S=1
    for (int cc = 0; cc < 16; cc++)
      for (int f = 0; f < 16; f++)
        runVec({cc[3:0], 3'b000, 4'd13, 1'b1, 4'h0, 4'h9, 8'd0, 4'h0},
               32'h0, {f[1:0], 30'h1}, f[2], f[3:0], "cond R3");

    // R1 exclusions
    runVec({4'hE, 3'b000, 4'd4, 1'b1, 4'h1, 4'h2, 7'd0, 1'b1, 4'h0}, 32'h5, 32'h6, 1'b0, 4'h5, "bit4 R1");
    runVec({4'hE, 3'b001, 4'd4, 1'b1, 4'h1, 4'h2, 8'd0, 4'h0}, 32'h5, 32'h6, 1'b0, 4'ha, "imm R1");
    runVec({4'hE, 3'b000, 4'd10, 1'b0, 4'h1, 4'h2, 8'd0, 4'h0}, 32'h5, 32'h6, 1'b0, 4'h3, "cmpNoS R1");

    // R11 idle cycle
    inValid = 1'b0;
    @(negedge clk);
    check("R11 idle outValid", {31'd0, outValid}, 32'd0);
    check("R11 idle wrEn", {31'd0, wrEn}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog R11 actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule